// File: doc/BRIEF.md
# Global Timer with Write-Acknowledge

This block is a memory-mapped timer peripheral. It holds a 64-bit free-running counter and one 64-bit comparator. The counter advances by one on each cycle of a tick-enable input while the start bit is set. When the counter reaches the comparator value, the block latches an interrupt status bit. An enable register gates that status onto a level interrupt output. The comparator can optionally advance itself by a programmable increment on every match, which gives a periodic tick interrupt without software rewriting the comparator.

Software reaches the block through a 32-bit register interface. The timing registers are the counter halves, the comparator halves, the increment and the control word. A write to one of them is not taken in at once. It takes effect a fixed number of cycles later, which models the slow timer clock domain. In that same cycle the block sets a sticky write-status bit for that register. Software polls the bit to learn that its write has landed, then clears the bit by writing a one to it. The counter halves are read independently and neither read latches the other. To get a consistent 64-bit value, software reads the upper half, then the lower half, then the upper half again, and retries if the two upper reads differ.

Top module: `gtimer_wack`

## Requirements
- R1: After a synchronous reset, every mapped register reads zero and `irq` is low.
- R2: The byte offsets are: counter low 0x00, counter high 0x04, counter write-status 0x08, comparator low 0x10, comparator high 0x14, increment 0x18, control 0x1C, interrupt status 0x20, interrupt enable 0x24, global write-status 0x28. Any other offset reads zero, and a write to it changes nothing.
- R3: A write to a timing register takes effect exactly LAT cycles (default 4) after the clock edge that samples it. Until then a read returns the old value. A new write to the same register while one is still pending replaces the pending data and restarts the LAT-cycle wait.
- R4: The write-status bits are as follows. In the counter write-status register, bit0 is counter low and bit1 is counter high. In the global write-status register, bit0 is comparator low, bit1 is comparator high, bit2 is increment and bit3 is control. Each bit sets in the same edge that its register takes the new value. Each bit is sticky and clears only when software writes 1 to its position; bits written 0 are left alone. If a set and a clear occur in the same cycle, the set wins.
- R5: Writes to the interrupt status, interrupt enable and write-status registers act on the next edge and set no write-status bit. Writes to unmapped offsets also set no write-status bit.
- R6: While control bit0 (start) is 1, each cycle with `tick_en` high adds one to the counter. Carries pass from the low half into the high half. The counter wraps from all ones to zero.
- R7: The counter holds its value in any cycle where start is 0 or `tick_en` is low. A committed counter write takes priority over counting in the same cycle.
- R8: With start and control bit1 (comparator enable) both set, the interrupt status bit0 sets at the edge where a tick brings the counter equal to the full 64-bit comparator. If control bit2 (auto-increment) is 0, the comparator is unchanged and no further match occurs while the count moves on.
- R9: If auto-increment is 1, each match adds the increment register to the comparator in the same edge, so a match recurs every increment ticks. A committed comparator write in that cycle takes priority.
- R10: Writing 1 to bit0 of the interrupt status register clears the status; a match in the same cycle wins. Bit0 of the interrupt enable register gates the status onto `irq`, which is high exactly when both bits are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Counter advance strobe, one count per high cycle |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Byte offset of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that `tick_en` and `wr_en` are clean single-cycle levels that change only between clock edges. They also assume that no counter write commits while the counter sits at all ones with a tick pending, unless the commit rule is intended to win; the wrap property excludes commit cycles for that reason. The bench drives every input half a cycle away from the active edge. It keeps `tick_en` low while timing-register writes are in flight, except where a test deliberately mixes the two. It picks comparator, increment and counter values at random from a fixed seed, within ranges where the bench's own 64-bit model of the counter and comparator predicts each match cycle exactly.

// File: rtl/gtw_pkg.sv
package gtw_pkg;

    localparam int DW    = 32;
    localparam int AW    = 6;
    localparam int NSLOT = 6;
    localparam int NDATA = 5;

    localparam logic [AW-1:0] A_CNT_LO = 6'h00;
    localparam logic [AW-1:0] A_CNT_HI = 6'h04;
    localparam logic [AW-1:0] A_CNT_WS = 6'h08;
    localparam logic [AW-1:0] A_CMP_LO = 6'h10;
    localparam logic [AW-1:0] A_CMP_HI = 6'h14;
    localparam logic [AW-1:0] A_INCR   = 6'h18;
    localparam logic [AW-1:0] A_CTRL   = 6'h1C;
    localparam logic [AW-1:0] A_INT_ST = 6'h20;
    localparam logic [AW-1:0] A_INT_EN = 6'h24;
    localparam logic [AW-1:0] A_G_WS   = 6'h28;

    // slot order: counter status bits take slots 0..1, global status 2..5
    typedef enum logic [2:0] {
        S_CNT_LO = 3'd0,
        S_CNT_HI = 3'd1,
        S_CMP_LO = 3'd2,
        S_CMP_HI = 3'd3,
        S_INCR   = 3'd4,
        S_CTRL   = 3'd5
    } slot_e;

    typedef struct packed {
        logic auto_inc;
        logic cmp_en;
        logic start;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic logic [AW-1:0] slot_addr(input int s);
        case (s)
            0:       return A_CNT_LO;
            1:       return A_CNT_HI;
            2:       return A_CMP_LO;
            3:       return A_CMP_HI;
            4:       return A_INCR;
            default: return A_CTRL;
        endcase
    endfunction

endpackage

// File: rtl/gtw_wr_slot.sv
module gtw_wr_slot #(
    parameter int W   = 32,
    parameter int LAT = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic         commit,
    output logic [W-1:0] dout
);
    localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;
    localparam logic [CW-1:0] CNT_INIT = CW'(LAT - 1);

    logic          busy_q;
    logic [CW-1:0] wait_q;
    logic [W-1:0]  data_q;

    // a fresh load cancels a commit due in the same cycle and restarts the wait
    assign commit = busy_q && (wait_q == '0) && !load;
    assign dout   = data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            wait_q <= '0;
            data_q <= '0;
        end else if (load) begin
            busy_q <= 1'b1;
            wait_q <= CNT_INIT;
            data_q <= din;
        end else if (commit) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            wait_q <= wait_q - 1'b1;
        end
    end

    generate
        if (LAT > 1) begin : g_early
            // R3: nothing lands in the cycle right after a write is taken
            assert_no_early_R3: assert property (@(posedge clk) disable iff (rst)
                load |=> !commit);
        end
    endgenerate

endmodule

// File: rtl/gtw_timer_core.sv
module gtw_timer_core
    import gtw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic [NSLOT-1:0]  commit,
    input  logic [DW-1:0]     cnt_lo_d,
    input  logic [DW-1:0]     cnt_hi_d,
    input  logic [DW-1:0]     cmp_lo_d,
    input  logic [DW-1:0]     cmp_hi_d,
    input  logic [DW-1:0]     incr_d,
    input  ctrl_t             ctrl_d,
    output logic [2*DW-1:0]   cnt,
    output logic [2*DW-1:0]   cmp,
    output logic [DW-1:0]     incr,
    output ctrl_t             ctrl,
    output logic              match
);
    logic [2*DW-1:0] cnt_q, cmp_q, cnt_inc;
    logic [DW-1:0]   incr_q;
    ctrl_t           ctrl_q;
    logic            cnt_wr, cmp_wr, counting;

    assign cnt_wr   = commit[S_CNT_LO] | commit[S_CNT_HI];
    assign cmp_wr   = commit[S_CMP_LO] | commit[S_CMP_HI];
    assign counting = ctrl_q.start & tick_en & ~cnt_wr;
    assign cnt_inc  = cnt_q + 1'b1;
    assign match    = counting & ctrl_q.cmp_en & (cnt_inc == cmp_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            cmp_q  <= '0;
            incr_q <= '0;
            ctrl_q <= '0;
        end else begin
            if (cnt_wr) begin
                if (commit[S_CNT_LO]) cnt_q[DW-1:0]    <= cnt_lo_d;
                if (commit[S_CNT_HI]) cnt_q[2*DW-1:DW] <= cnt_hi_d;
            end else if (counting) begin
                cnt_q <= cnt_inc;
            end

            if (cmp_wr) begin
                if (commit[S_CMP_LO]) cmp_q[DW-1:0]    <= cmp_lo_d;
                if (commit[S_CMP_HI]) cmp_q[2*DW-1:DW] <= cmp_hi_d;
            end else if (match && ctrl_q.auto_inc) begin
                cmp_q <= cmp_q + {{DW{1'b0}}, incr_q};
            end

            if (commit[S_INCR]) incr_q <= incr_d;
            if (commit[S_CTRL]) ctrl_q <= ctrl_d;
        end
    end

    assign cnt  = cnt_q;
    assign cmp  = cmp_q;
    assign incr = incr_q;
    assign ctrl = ctrl_q;

    // R7: no tick, no start or no landed write leaves the count alone
    assert_count_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!(ctrl_q.start && tick_en) && !cnt_wr) |=> $stable(cnt_q));

    // R6: a counting step from all ones lands on zero
    assert_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '1 && ctrl_q.start && tick_en && !cnt_wr) |=> (cnt_q == '0));

    // R8: one-shot mode leaves the comparator where it was
    assert_oneshot_R8: assert property (@(posedge clk) disable iff (rst)
        (match && !ctrl_q.auto_inc && !cmp_wr) |=> $stable(cmp_q));

endmodule

// File: rtl/gtw_status.sv
module gtw_status
    import gtw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NSLOT-1:0] commit,
    input  logic             wr_cnt_ws,
    input  logic             wr_g_ws,
    input  logic             wr_int_st,
    input  logic             wr_int_en,
    input  logic [3:0]       wbits,
    input  logic             match,
    output logic [1:0]       cnt_ws,
    output logic [3:0]       g_ws,
    output logic             int_st,
    output logic             int_en,
    output logic             irq
);
    logic [1:0] cnt_ws_q, cnt_clr;
    logic [3:0] g_ws_q, g_clr;
    logic       int_st_q, int_en_q, int_clr;

    assign cnt_clr = wr_cnt_ws ? wbits[1:0] : 2'b00;
    assign g_clr   = wr_g_ws   ? wbits     : 4'b0000;
    assign int_clr = wr_int_st & wbits[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_ws_q <= '0;
            g_ws_q   <= '0;
            int_st_q <= 1'b0;
            int_en_q <= 1'b0;
        end else begin
            cnt_ws_q <= (cnt_ws_q & ~cnt_clr) | commit[S_CNT_HI:S_CNT_LO];
            g_ws_q   <= (g_ws_q & ~g_clr) | commit[S_CTRL:S_CMP_LO];
            int_st_q <= (int_st_q & ~int_clr) | match;
            if (wr_int_en) int_en_q <= wbits[0];
        end
    end

    assign cnt_ws = cnt_ws_q;
    assign g_ws   = g_ws_q;
    assign int_st = int_st_q;
    assign int_en = int_en_q;
    assign irq    = int_st_q & int_en_q;

    generate
        for (genvar i = 0; i < 4; i++) begin : g_chk
            // R4: a global status bit only drops after a one was written there
            assert_wstat_sticky_R4: assert property (@(posedge clk) disable iff (rst)
                $fell(g_ws_q[i]) |-> $past(g_clr[i]));
            // R4: a global status bit only rises with its register landing
            assert_wstat_rise_R4: assert property (@(posedge clk) disable iff (rst)
                $rose(g_ws_q[i]) |-> $past(commit[i+2]));
        end
    endgenerate

    // R10: the interrupt status only drops after a clear write
    assert_int_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(int_st_q) |-> $past(int_clr));

endmodule

// File: rtl/gtimer_wack.sv
module gtimer_wack
    import gtw_pkg::*;
#(
    parameter int LAT = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_en,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          irq
);
    logic [NSLOT-1:0]     hit, commit;
    logic [DW-1:0]        sdata [NDATA];
    ctrl_t                ctrl_d, ctrl;
    logic [2*DW-1:0]      cnt, cmp;
    logic [DW-1:0]        incr;
    logic                 match, int_st, int_en;
    logic [1:0]           cnt_ws;
    logic [3:0]           g_ws;
    logic [CTRL_W-1:0]    ctrl_raw;

    generate
        for (genvar i = 0; i < NSLOT; i++) begin : g_hit
            assign hit[i] = wr_en && (addr == slot_addr(i));
        end
        for (genvar i = 0; i < NDATA; i++) begin : g_slot
            gtw_wr_slot #(.W(DW), .LAT(LAT)) i_slot (
                .clk    (clk),
                .rst    (rst),
                .load   (hit[i]),
                .din    (wdata),
                .commit (commit[i]),
                .dout   (sdata[i])
            );
        end
    endgenerate

    gtw_wr_slot #(.W(CTRL_W), .LAT(LAT)) i_ctrl_slot (
        .clk    (clk),
        .rst    (rst),
        .load   (hit[S_CTRL]),
        .din    (wdata[CTRL_W-1:0]),
        .commit (commit[S_CTRL]),
        .dout   (ctrl_raw)
    );
    assign ctrl_d = ctrl_t'(ctrl_raw);

    gtw_timer_core i_core (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick_en),
        .commit   (commit),
        .cnt_lo_d (sdata[S_CNT_LO]),
        .cnt_hi_d (sdata[S_CNT_HI]),
        .cmp_lo_d (sdata[S_CMP_LO]),
        .cmp_hi_d (sdata[S_CMP_HI]),
        .incr_d   (sdata[S_INCR]),
        .ctrl_d   (ctrl_d),
        .cnt      (cnt),
        .cmp      (cmp),
        .incr     (incr),
        .ctrl     (ctrl),
        .match    (match)
    );

    gtw_status i_status (
        .clk       (clk),
        .rst       (rst),
        .commit    (commit),
        .wr_cnt_ws (wr_en && addr == A_CNT_WS),
        .wr_g_ws   (wr_en && addr == A_G_WS),
        .wr_int_st (wr_en && addr == A_INT_ST),
        .wr_int_en (wr_en && addr == A_INT_EN),
        .wbits     (wdata[3:0]),
        .match     (match),
        .cnt_ws    (cnt_ws),
        .g_ws      (g_ws),
        .int_st    (int_st),
        .int_en    (int_en),
        .irq       (irq)
    );

    always_comb begin
        case (addr)
            A_CNT_LO: rdata = cnt[DW-1:0];
            A_CNT_HI: rdata = cnt[2*DW-1:DW];
            A_CNT_WS: rdata = {{(DW-2){1'b0}}, cnt_ws};
            A_CMP_LO: rdata = cmp[DW-1:0];
            A_CMP_HI: rdata = cmp[2*DW-1:DW];
            A_INCR:   rdata = incr;
            A_CTRL:   rdata = {{(DW-CTRL_W){1'b0}}, ctrl};
            A_INT_ST: rdata = {{(DW-1){1'b0}}, int_st};
            A_INT_EN: rdata = {{(DW-1){1'b0}}, int_en};
            A_G_WS:   rdata = {{(DW-4){1'b0}}, g_ws};
            default:  rdata = '0;
        endcase
    end

endmodule

// File: tb/test_gtimer_wack.sv
module test_gtimer_wack;
    localparam int LAT = 4;
    localparam logic [5:0] O_CNT_LO = 6'h00, O_CNT_HI = 6'h04, O_CNT_WS = 6'h08;
    localparam logic [5:0] O_CMP_LO = 6'h10, O_CMP_HI = 6'h14, O_INCR = 6'h18;
    localparam logic [5:0] O_CTRL = 6'h1C, O_INT_ST = 6'h20, O_INT_EN = 6'h24, O_G_WS = 6'h28;

    logic        clk = 1'b0, rst = 1'b1, tick_en = 1'b0, wr_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int          checks = 0, errors = 0;

    gtimer_wack #(.LAT(LAT)) i_gtimer_wack (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

    always #4 clk = ~clk;

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run hung, actual running expected done");
        finish_run();
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] gws_bit(input logic [5:0] a);
        case (a)
            O_CMP_LO: return 32'd1;
            O_CMP_HI: return 32'd2;
            O_INCR:   return 32'd4;
            default:  return 32'd8;
        endcase
    endfunction

    // all tasks start and end just after a falling edge
    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick(input int n);
        repeat (n) begin tick_en = 1'b1; @(negedge clk); end
        tick_en = 1'b0;
    endtask

    task automatic put(input logic [5:0] a, input logic [31:0] d);
        wr(a, d); idle(LAT);
    endtask

    task automatic set_cnt(input logic [63:0] v);
        wr(O_CNT_LO, v[31:0]); wr(O_CNT_HI, v[63:32]); idle(LAT);
    endtask

    task automatic rd_cnt(output logic [63:0] v);
        logic [31:0] lo, hi;
        rd(O_CNT_HI, hi); rd(O_CNT_LO, lo); v = {hi, lo};
    endtask

    initial begin
        logic [31:0] r, v, old;
        logic [63:0] c, exp_cnt, exp_cmp;
        logic [5:0]  a;
        logic [31:0] shadow [3];
        logic [31:0] inc;
        int          fires;
        r = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int i = 0; i < 11; i++) begin
            rd(6'(i * 4), r); chk("R1 reset read", {32'd0, r}, 64'd0);
        end
        chk("R1 reset irq", {63'd0, irq}, 64'd0);

        // R3/R4 random writes to comparator and increment, checked across the latency
        shadow[0] = 0; shadow[1] = 0; shadow[2] = 0;
        for (int k = 0; k < 8; k++) begin
            int s;
            s = int'($urandom % 3);
            a = (s == 0) ? O_CMP_LO : (s == 1) ? O_CMP_HI : O_INCR;
            v = $urandom;
            old = shadow[s];
            wr(a, v);
            idle(LAT - 1);
            rd(a, r);    chk("R3 old value during latency", {32'd0, r}, {32'd0, old});
            rd(O_G_WS, r); chk("R4 status clear before landing", {32'd0, r}, 64'd0);
            idle(1);
            rd(a, r);    chk("R3 new value after latency", {32'd0, r}, {32'd0, v});
            rd(O_G_WS, r); chk("R4 status set on landing", {32'd0, r}, {32'd0, gws_bit(a)});
            wr(O_G_WS, ~gws_bit(a));
            rd(O_G_WS, r); chk("R4 zero write keeps status", {32'd0, r}, {32'd0, gws_bit(a)});
            wr(O_G_WS, gws_bit(a));
            rd(O_G_WS, r); chk("R4 write one clears status", {32'd0, r}, 64'd0);
            shadow[s] = v;
        end

        // R3 restart: two back-to-back writes to the same register
        wr(O_INCR, 32'hAAAA_0001); wr(O_INCR, 32'h5555_0002);
        idle(LAT - 1);
        rd(O_INCR, r); chk("R3 restart keeps old value", {32'd0, r}, {32'd0, shadow[2]});
        idle(1);
        rd(O_INCR, r); chk("R3 restart lands second data", {32'd0, r}, 64'h5555_0002);
        wr(O_G_WS, 32'hF);

        // R4 counter status bits, R5 no status for other writes
        wr(O_CNT_LO, 32'h1234_5678); idle(LAT);
        rd(O_CNT_WS, r); chk("R4 counter low status bit0", {32'd0, r}, 64'd1);
        wr(O_CNT_HI, 32'h0000_0009); idle(LAT);
        rd(O_CNT_WS, r); chk("R4 counter high status bit1", {32'd0, r}, 64'd3);
        wr(O_CNT_WS, 32'd1);
        rd(O_CNT_WS, r); chk("R4 counter status low cleared", {32'd0, r}, 64'd2);
        wr(O_CNT_WS, 32'd2);
        rd_cnt(c); chk("R6 counter halves readable", c, 64'h9_1234_5678);
        put(O_CTRL, 32'd0);
        rd(O_G_WS, r); chk("R4 control status bit3", {32'd0, r}, 64'd8);
        wr(O_G_WS, 32'hF);
        wr(O_INT_EN, 32'd0); wr(6'h2C, 32'hFFFF_FFFF); wr(6'h3C, 32'h7); idle(LAT);
        rd(O_G_WS, r);   chk("R5 no global status from other writes", {32'd0, r}, 64'd0);
        rd(O_CNT_WS, r); chk("R5 no counter status from other writes", {32'd0, r}, 64'd0);
        rd(6'h2C, r);    chk("R2 unmapped reads zero", {32'd0, r}, 64'd0);
        rd(6'h0C, r);    chk("R2 unmapped reads zero", {32'd0, r}, 64'd0);

        // R7 stopped counter ignores ticks
        tick(5);
        rd_cnt(c); chk("R7 hold while stopped", c, 64'h9_1234_5678);

        // R6 random counting
        put(O_CTRL, 32'd1);
        exp_cnt = 64'h9_1234_5678;
        idle(6);
        rd_cnt(c); chk("R7 hold without tick", c, exp_cnt);
        for (int i = 0; i < 60; i++) begin
            logic b;
            b = 1'($urandom % 2);
            tick_en = b; exp_cnt += {63'd0, b};
            @(negedge clk);
        end
        tick_en = 1'b0;
        rd_cnt(c); chk("R6 random tick count", c, exp_cnt);

        // R6 carry into the high half and full wrap
        set_cnt(64'h5_FFFF_FFFF); tick(1);
        rd_cnt(c); chk("R6 carry into high half", c, 64'h6_0000_0000);
        set_cnt(64'hFFFF_FFFF_FFFF_FFFE); tick(3);
        rd_cnt(c); chk("R6 wrap to zero", c, 64'h1);

        // R7 counter write wins over a tick in the same cycle
        wr(O_CNT_LO, 32'h100); tick_en = 1'b1; idle(LAT + 2); tick_en = 1'b0;
        rd_cnt(c); chk("R7 write wins over tick", c, 64'h102);

        // R8 one-shot match and R10 gating
        c = {32'h3, $urandom};
        set_cnt(c);
        exp_cmp = c + 64'd5;
        wr(O_CMP_LO, exp_cmp[31:0]); wr(O_CMP_HI, exp_cmp[63:32]); idle(LAT);
        put(O_CTRL, 32'd3);
        wr(O_INT_ST, 32'd1);
        tick(4);
        rd(O_INT_ST, r); chk("R8 no match before comparator", {32'd0, r}, 64'd0);
        tick(1);
        rd(O_INT_ST, r); chk("R8 match sets status", {32'd0, r}, 64'd1);
        chk("R10 irq masked when disabled", {63'd0, irq}, 64'd0);
        wr(O_INT_EN, 32'd1);
        chk("R10 irq high when enabled", {63'd0, irq}, 64'd1);
        wr(O_INT_ST, 32'd0);
        rd(O_INT_ST, r); chk("R10 zero write keeps status", {32'd0, r}, 64'd1);
        wr(O_INT_ST, 32'd1);
        rd(O_INT_ST, r); chk("R10 clear status", {32'd0, r}, 64'd0);
        chk("R10 irq drops after clear", {63'd0, irq}, 64'd0);
        tick(12);
        rd(O_INT_ST, r); chk("R8 one-shot does not refire", {32'd0, r}, 64'd0);
        rd(O_CMP_LO, r); chk("R8 comparator unchanged", {32'd0, r}, {32'd0, exp_cmp[31:0]});

        // R9 periodic auto-increment across a half carry
        put(O_CTRL, 32'd0);
        inc = 32'd3 + ($urandom % 6);
        c = {32'h7, 32'hFFFF_FFF0};
        set_cnt(c);
        exp_cmp = c + {32'd0, inc};
        wr(O_CMP_LO, exp_cmp[31:0]); wr(O_CMP_HI, exp_cmp[63:32]); wr(O_INCR, inc); idle(LAT);
        put(O_CTRL, 32'd7);
        exp_cnt = c; fires = 0;
        for (int i = 0; i < 40; i++) begin
            logic f;
            tick(1);
            exp_cnt += 64'd1;
            f = (exp_cnt == exp_cmp);
            if (f) begin exp_cmp += {32'd0, inc}; fires++; end
            rd(O_INT_ST, r); chk("R9 periodic status", {32'd0, r}, {63'd0, f});
            chk("R10 irq follows status", {63'd0, irq}, {63'd0, f});
            if (f) wr(O_INT_ST, 32'd1);
        end
        rd(O_CMP_HI, v); rd(O_CMP_LO, r);
        chk("R9 comparator advanced", {v, r}, exp_cmp);
        chk("R9 fire count", 64'(fires), 64'(40 / inc));

        finish_run();
    end
endmodule